// File: doc/BRIEF.md
# Keyed Function-Select Guard

This block keeps an 8-bit function-select vector safe from stray software writes. The vector drives the pin-function multiplexers elsewhere on the chip. It can be changed only through a per-bit permission mask. The mask in turn can be rewritten only after software has stored a 32-bit unlock key in a dedicated key register. After reset the key register is in the locked state and every mask bit is set. While the mask stays at all ones, the function vector can be written freely. Narrowing the mask later freezes chosen bits against change.

The block sits on a simple single-cycle register port. A request is presented for one clock cycle together with a write flag, a 12-bit byte offset and 32-bit write data. One cycle later the block returns the read data and an error flag. A read-only table of identification bytes sits at the top of the window, one byte per word. The table is a parameter, so two builds can report different identities.

Top module: `keyed_fnsel_guard`

## Requirements
- R1: After reset the key state is locked (the key register at offset 0x520 reads 1), the permission mask at offset 0x524 reads 0xFF, and the function vector (offset 0x420 and `fn_out`) is 0x00.
- R2: A write of exactly 0x0ACCE551 to offset 0x520 unlocks the block, and the register then reads 0. A write of any other value locks it, and the register then reads 1.
- R3: A write to offset 0x524 replaces the permission mask with write-data bits 7:0 only while the block is unlocked. While locked, the write leaves the mask unchanged.
- R4: A write to offset 0x420 sets each function bit whose mask bit is 1 to the matching write-data bit. It leaves each function bit whose mask bit is 0 unchanged. `fn_out` shows the new value in the cycle after the request.
- R5: `rdata` is registered. In the cycle after a read request it holds the addressed register, zero-extended to 32 bits. In the cycle after a write request it holds zero.
- R6: A read of offset 0xFD0 + 4k (k = 0..11) returns identification byte k, which is bits 8k+7:8k of the `ID_TABLE` parameter, in `rdata` bits 7:0. All other `rdata` bits are zero. Writes to this range change nothing and do not raise `err`.
- R7: A request to any other offset, including a mapped offset whose bits 1:0 are not zero, reads zero and changes no state. It also raises `err` for exactly the one cycle after the request. Requests to mapped offsets leave `err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Register access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `req` |
| err | output | 1 | Undecoded-access flag, the cycle after `req` |
| fn_out | output | FN_W | Function-select vector |

## Verification
The bench builds two copies on one shared bus, both with `FN_W` = 8. The copies differ only in their `ID_TABLE` values, so a table that is wired to the wrong word or byte lane, or that ignores the parameter, gives a mismatch on one copy or the other. Because both copies see the same accesses, the bench also compares their lock, mask and function behaviour on every response. The access order walks the block locked, unlocked and relocked, with a partial mask in place, so that both frozen and writable function bits are exercised.

// File: rtl/gk_pkg.sv
package gk_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int ID_WORDS = 12;
    localparam int IDX_W    = $clog2(ID_WORDS);

    localparam logic [ADDR_W-1:0] OFS_FNSEL  = 12'h420;
    localparam logic [ADDR_W-1:0] OFS_KEY    = 12'h520;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h524;
    localparam logic [ADDR_W-1:0] OFS_IDBASE = 12'hFD0;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FN,
        SEL_KEY,
        SEL_MASK,
        SEL_ID
    } sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rsp_t;

    function automatic sel_e decode_sel(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00)  return SEL_NONE;
        if (a == OFS_FNSEL)   return SEL_FN;
        if (a == OFS_KEY)     return SEL_KEY;
        if (a == OFS_MASK)    return SEL_MASK;
        if (a >= OFS_IDBASE)  return SEL_ID;
        return SEL_NONE;
    endfunction

    function automatic logic [IDX_W-1:0] id_index(input logic [ADDR_W-3:0] word);
        return IDX_W'(word - (ADDR_W-2)'(OFS_IDBASE >> 2));
    endfunction
endpackage

// File: rtl/gk_decode.sv
module gk_decode
    import gk_pkg::*;
(
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_fn,
    output logic              wr_key,
    output logic              wr_mask
);
    always_comb begin
        sel     = decode_sel(addr);
        idx     = id_index(addr[ADDR_W-1:2]);
        wr_fn   = req && wr && (sel == SEL_FN);
        wr_key  = req && wr && (sel == SEL_KEY);
        wr_mask = req && wr && (sel == SEL_MASK);
    end
endmodule

// File: rtl/gk_lock_ctrl.sv
module gk_lock_ctrl
    import gk_pkg::*;
#(
    parameter int FN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_key,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked,
    output logic [FN_W-1:0]   mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b1;
            mask   <= '1;
        end else begin
            if (wr_key)
                locked <= (wdata != UNLOCK_KEY);
            if (wr_mask && !locked)
                mask <= wdata[FN_W-1:0];
        end
    end
endmodule

// File: rtl/gk_fn_reg.sv
module gk_fn_reg #(
    parameter int FN_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_fn,
    input  logic [FN_W-1:0] wbits,
    input  logic [FN_W-1:0] mask,
    output logic [FN_W-1:0] fn
);
    logic [FN_W-1:0] fn_next;

    for (genvar g = 0; g < FN_W; g++) begin : g_bit
        assign fn_next[g] = mask[g] ? wbits[g] : fn[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            fn <= '0;
        else if (wr_fn)
            fn <= fn_next;
    end
endmodule

// File: rtl/gk_id_rom.sv
module gk_id_rom
    import gk_pkg::*;
#(
    parameter logic [8*ID_WORDS-1:0] ID_TABLE = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       id_byte
);
    logic [7:0] rom [ID_WORDS];

    for (genvar g = 0; g < ID_WORDS; g++) begin : g_entry
        assign rom[g] = ID_TABLE[8*g +: 8];
    end

    always_comb begin
        id_byte = 8'h00;
        for (int i = 0; i < ID_WORDS; i++)
            if (idx == IDX_W'(i))
                id_byte = rom[i];
    end
endmodule

// File: rtl/keyed_fnsel_guard.sv
module keyed_fnsel_guard
    import gk_pkg::*;
#(
    parameter int                    FN_W     = 8,
    parameter logic [8*ID_WORDS-1:0] ID_TABLE = 96'hB1_05_F0_0D_00_24_19_7C_00_00_00_00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic [FN_W-1:0]   fn_out
);
    sel_e             sel;
    logic [IDX_W-1:0] idx;
    logic             wr_fn, wr_key, wr_mask;
    logic             lock_q;
    logic [FN_W-1:0]  mask_q;
    logic [7:0]       id_byte;
    logic [DATA_W-1:0] rd_mux;
    rsp_t             rsp_q;

    gk_decode u_dec (
        .req(req), .wr(wr), .addr(addr), .sel(sel), .idx(idx),
        .wr_fn(wr_fn), .wr_key(wr_key), .wr_mask(wr_mask)
    );

    gk_lock_ctrl #(.FN_W(FN_W)) u_lock (
        .clk(clk), .rst(rst), .wr_key(wr_key), .wr_mask(wr_mask),
        .wdata(wdata), .locked(lock_q), .mask(mask_q)
    );

    gk_fn_reg #(.FN_W(FN_W)) u_fn (
        .clk(clk), .rst(rst), .wr_fn(wr_fn), .wbits(wdata[FN_W-1:0]),
        .mask(mask_q), .fn(fn_out)
    );

    gk_id_rom #(.ID_TABLE(ID_TABLE)) u_id (
        .idx(idx), .id_byte(id_byte)
    );

    always_comb begin
        case (sel)
            SEL_FN:   rd_mux = DATA_W'(fn_out);
            SEL_KEY:  rd_mux = DATA_W'(lock_q);
            SEL_MASK: rd_mux = DATA_W'(mask_q);
            SEL_ID:   rd_mux = DATA_W'(id_byte);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.err <= req && (sel == SEL_NONE);
            if (req)
                rsp_q.rdata <= wr ? '0 : rd_mux;
        end
    end

    assign rdata = rsp_q.rdata;
    assign err   = rsp_q.err;
endmodule

// File: rtl/keyed_fnsel_guard_chk.sv
module keyed_fnsel_guard_chk
    import gk_pkg::*;
#(
    parameter int FN_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              err,
    input logic [FN_W-1:0]   fn_out,
    input logic              locked,
    input logic [FN_W-1:0]   mask
);
    // R1
    reset_values_chk: assert property (@(posedge clk)
        rst |=> (locked && mask == '1 && fn_out == '0));

    // R2
    unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
        (req && wr && addr == OFS_KEY && wdata == UNLOCK_KEY) |=> !locked);

    // R3
    mask_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(mask));

    // R4
    fn_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (req && wr && addr == OFS_FNSEL) |=>
            (((fn_out ^ $past(fn_out)) & ~$past(mask)) == '0));

    // R4
    fn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req && wr && addr == OFS_FNSEL) |=> $stable(fn_out));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> !err);
endmodule

bind keyed_fnsel_guard keyed_fnsel_guard_chk #(.FN_W(FN_W)) u_chk (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .err(err), .fn_out(fn_out), .locked(lock_q), .mask(mask_q)
);

// File: tb/test_keyed_fnsel_guard.sv
module test_keyed_fnsel_guard;
    localparam logic [95:0] TBL_A = 96'hB1_05_F0_0D_00_24_19_7C_00_00_00_00;
    localparam logic [95:0] TBL_B = 96'hB1_05_F0_0D_01_58_00_7C_00_00_00_00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr  = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_b;
    logic        err, err_b;
    logic [7:0]  fn_out, fn_b;

    always #5 clk = ~clk;

    keyed_fnsel_guard #(.FN_W(8), .ID_TABLE(TBL_A)) i_keyed_fnsel_guard (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .err(err), .fn_out(fn_out)
    );

    keyed_fnsel_guard #(.FN_W(8), .ID_TABLE(TBL_B)) i_keyed_fnsel_guard_alt (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata_b), .err(err_b), .fn_out(fn_b)
    );

    typedef struct {
        string       tag;
        logic [31:0] rd_a;
        logic [31:0] rd_b;
        logic        er;
        logic [7:0]  fn;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit pend = 0;
    bit done = 0;

    // bench model of the requirements
    bit       m_locked = 1;
    bit [7:0] m_mask   = 8'hFF;
    bit [7:0] m_fn     = 8'h00;

    task automatic access(input bit w, input logic [11:0] a, input logic [31:0] d, input string tag);
        item_t it;
        bit    mapped_id;
        int    k;
        it.tag  = tag;
        it.rd_a = '0;
        it.rd_b = '0;
        it.er   = 0;
        mapped_id = (a >= 12'hFD0) && (a[1:0] == 2'b00);
        k = (int'(a) - 'hFD0) / 4;
        if (a == 12'h420) begin
            if (!w) it.rd_a = {24'h0, m_fn};
            else m_fn = (m_fn & ~m_mask) | (d[7:0] & m_mask);
        end else if (a == 12'h520) begin
            if (!w) it.rd_a = {31'h0, m_locked};
            else m_locked = (d != 32'h0ACC_E551);
        end else if (a == 12'h524) begin
            if (!w) it.rd_a = {24'h0, m_mask};
            else if (!m_locked) m_mask = d[7:0];
        end else if (mapped_id) begin
            if (!w) begin
                it.rd_a = {24'h0, TBL_A[8*k +: 8]};
                it.rd_b = {24'h0, TBL_B[8*k +: 8]};
            end
        end else begin
            it.er = 1;
        end
        if (!mapped_id) it.rd_b = it.rd_a;
        it.fn = m_fn;
        q.push_back(it);
        req   = 1'b1;
        wr    = w;
        addr  = a;
        wdata = d;
        @(negedge clk);
        req   = 1'b0;
    endtask

    always @(posedge clk) pend = req && !rst;

    always @(negedge clk) begin
        if (pend && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (rdata !== it.rd_a || rdata_b !== it.rd_b || err !== it.er || err_b !== it.er
                || fn_out !== it.fn || fn_b !== it.fn) begin
                errors++;
                $display("FAIL %s: rdata=%h/%h err=%b/%b fn=%h/%h expected rdata=%h/%h err=%b fn=%h",
                         it.tag, rdata, rdata_b, err, err_b, fn_out, fn_b,
                         it.rd_a, it.rd_b, it.er, it.fn);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        access(0, 12'h520, 0, "R1 key reg");
        access(0, 12'h524, 0, "R1 mask reg");
        access(0, 12'h420, 0, "R1 fn reg");
        // R4 full mask write, R5 write response is zero
        access(1, 12'h420, 32'hFFFF_FFA5, "R4 R5 fn write full mask");
        access(0, 12'h420, 0, "R5 fn readback");
        // R3 mask write while locked ignored
        access(1, 12'h524, 32'h0000_000F, "R3 locked mask write");
        access(0, 12'h524, 0, "R3 mask unchanged");
        // R2 near-miss key keeps lock
        access(1, 12'h520, 32'h0ACC_E550, "R2 wrong key");
        access(0, 12'h520, 0, "R2 still locked");
        access(1, 12'h520, 32'h0ACC_E551, "R2 key");
        access(0, 12'h520, 0, "R2 unlocked reads 0");
        // R3 unlocked mask write keeps low 8 bits
        access(1, 12'h524, 32'h1234_563C, "R3 unlocked mask write");
        access(0, 12'h524, 0, "R3 mask low byte");
        // R4 partial mask
        access(1, 12'h420, 32'h0000_005A, "R4 partial mask write");
        access(0, 12'h420, 0, "R4 partial readback");
        // R2 relock with another value, R3 then frozen
        access(1, 12'h520, 32'h0000_0000, "R2 relock");
        access(0, 12'h520, 0, "R2 relocked reads 1");
        access(1, 12'h524, 32'h0000_00FF, "R3 relocked mask write");
        access(0, 12'h524, 0, "R3 mask kept");
        access(1, 12'h420, 32'h0000_0000, "R4 frozen bits kept");
        // R6 identification bytes, both tables
        for (int k = 0; k < 12; k++)
            access(0, 12'(12'hFD0 + 4*k), 0, "R6 id byte");
        access(1, 12'hFD4, 32'hFFFF_FFFF, "R6 id write ignored");
        access(0, 12'hFD4, 0, "R6 id after write");
        // R7 undecoded accesses
        access(0, 12'h424, 0, "R7 undecoded read");
        access(1, 12'h600, 32'hFFFF_FFFF, "R7 undecoded write");
        access(1, 12'h521, 32'h0ACC_E551, "R7 misaligned key write");
        access(0, 12'h520, 0, "R7 lock untouched");
        access(0, 12'h000, 0, "R7 low offset read");
        access(0, 12'h420, 0, "R7 fn untouched");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule